// File: doc/BRIEF.md
# USB Bulk-Out Frame Assembler

This block sits between a USB device controller's bulk-out endpoint and an Ethernet transmit MAC. It joins consecutive USB data packets into one Ethernet frame and writes the frame into a circular frame buffer. Each packet is accepted or refused as soon as it starts, depending on free buffer space. The controller then returns ACK or NAK to the host, and a refused packet is simply sent again later by the host. A packet shorter than the maximum packet size closes the frame, and so does a packet with no data at all. When a non-empty frame closes, its start address and length go into a small descriptor queue that the MAC drains. When the MAC reports that a frame has been transmitted, it returns that frame's byte count to the free-space counter.

The speed mode is sampled when each packet starts. It selects a maximum packet size of 64 bytes (full speed) or 512 bytes (high speed). The buffer holds 4608 bytes, which is about three maximum frames. A frame that grows past 1518 bytes is thrown away when it closes.

The controller is a four-state machine:
- `ST_IDLE` waits for a packet start. It moves to `ST_RECV` when the packet can be accepted and to `ST_DROP` when it cannot.
- `ST_RECV` writes bytes into the buffer. `ST_DROP` ignores bytes.
- Both `ST_RECV` and `ST_DROP` move to `ST_DONE` on packet end.
- `ST_DONE` presents the handshake for one cycle, closes the frame if the packet was short, and returns to `ST_IDLE`.

Top module: `usb_frame_asm`

## Requirements
- R1: The maximum packet size is 512 bytes when `hs_mode` is 1 and 64 bytes when it is 0. It is sampled in the cycle `pkt_start` is high and holds for that whole packet.
- R2: A packet is accepted when, at its start, free space is at least the maximum packet size and the descriptor queue is not full. `hs_valid` is high for exactly one cycle, in the cycle after the clock edge that samples `pkt_end`. In that cycle `hs_ack` is 1 for an accepted packet and 0 for a refused one.
- R3: A refused (NAK) packet writes no byte, consumes no space and leaves the frame in progress unchanged.
- R4: Bytes of an accepted packet are written one per `in_valid` cycle at consecutive addresses. The address wraps from 4607 to 0. Bytes beyond the maximum packet size of a packet are neither written nor counted.
- R5: An accepted packet with fewer bytes than the maximum packet size, including zero bytes, ends the current frame. A full-size packet continues it.
- R6: When a frame ends with 1 to 1518 bytes, a descriptor holding its start address and length becomes visible on `txq_valid`/`txq_addr`/`txq_len` one cycle after the handshake cycle. A frame that ends with no bytes produces no descriptor.
- R7: A frame that receives more than 1518 bytes stops being written. When it ends it produces no descriptor, its written bytes are returned to free space, and the next frame starts at that frame's start address.
- R8: Free space starts at 4608 bytes. It drops by one per written byte and rises by `tx_done_len` in each cycle `tx_done` is high.
- R9: Descriptors leave the queue in the order frames ended. One leaves on each clock edge with `txq_pop` and `txq_valid` both high. The queue holds 8 entries.
- R10: After reset, `hs_valid`, `mem_we` and `txq_valid` are 0, and the first frame starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | 1 = high speed (512-byte packets), 0 = full speed (64) |
| pkt_start | input | 1 | One-cycle pulse opening a USB data packet |
| pkt_end | input | 1 | One-cycle pulse closing the packet, after its last byte |
| in_valid | input | 1 | A packet data byte is present |
| in_data | input | 8 | Packet data byte |
| hs_valid | output | 1 | Handshake decision is valid |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| mem_we | output | 1 | Frame buffer write enable |
| mem_addr | output | 13 | Frame buffer write address |
| mem_wdata | output | 8 | Frame buffer write data |
| txq_valid | output | 1 | A finished frame descriptor is available |
| txq_addr | output | 13 | Start address of the head frame |
| txq_len | output | 11 | Byte length of the head frame |
| txq_pop | input | 1 | MAC takes the head descriptor |
| tx_done | input | 1 | MAC finished sending a frame |
| tx_done_len | input | 11 | Length of the frame being released |

## Verification
Directed frames in both speed modes end with a short packet, with a zero-length packet, or with a packet longer than the maximum. Comparing the descriptor lengths separates the short-packet rule from the overlong-packet cap, and tells the two speed modes apart. The buffer is filled with 1000-byte frames until a refusal appears, and the queue is filled with eight tiny frames. These show whether the space test and the queue-full test each cause NAK on their own, and whether a refused packet really writes nothing. A 1536-byte frame shows whether an oversize frame is dropped and its space rewound. Random packet lengths mixed with random MAC releases cover address wrap and many interleavings of writes and releases.

// File: rtl/fa_pkg.sv
package fa_pkg;

    // Controller states: wait, store a packet, skip a refused packet, report.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2,
        ST_DONE = 2'd3
    } fa_state_e;

endpackage

// File: rtl/fa_space.sv
// Free byte counter for the frame buffer.
module fa_space #(
    parameter int BUF_BYTES = 4608,
    parameter int CNT_W     = 13,
    parameter int LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec,
    input  logic             give_a,
    input  logic [LEN_W-1:0] give_a_len,
    input  logic             give_b,
    input  logic [LEN_W-1:0] give_b_len,
    output logic [CNT_W-1:0] free_cnt
);

    localparam int SUM_W = CNT_W + 2;

    logic [SUM_W-1:0] sum_nx;

    always_comb begin
        sum_nx = SUM_W'(free_cnt);
        if (give_a) sum_nx = sum_nx + SUM_W'(give_a_len);
        if (give_b) sum_nx = sum_nx + SUM_W'(give_b_len);
        if (dec)    sum_nx = sum_nx - SUM_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_cnt <= CNT_W'(BUF_BYTES);
        else        free_cnt <= CNT_W'(sum_nx);
    end

endmodule

// File: rtl/fa_desc_fifo.sv
// Small FIFO of finished frame descriptors.
module fa_desc_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wr_p;
    logic [PW-1:0] rd_p;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign valid   = (cnt != '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = slot[rd_p];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p <= '0;
            rd_p <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                slot[wr_p] <= din;
                wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
            end
            if (do_pop) rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/fa_ctrl.sv
// Packet acceptance and frame assembly state machine.
module fa_ctrl
    import fa_pkg::*;
#(
    parameter int BUF_BYTES = 4608,
    parameter int MAX_FRAME = 1518,
    parameter int FS_MPS    = 64,
    parameter int HS_MPS    = 512,
    parameter int ADDR_W    = 13,
    parameter int LEN_W     = 11,
    parameter int CNT_W     = 13,
    parameter int PC_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_mode,
    input  logic              pkt_start,
    input  logic              pkt_end,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic [CNT_W-1:0]  free_cnt,
    input  logic              q_full,
    output logic              hs_valid,
    output logic              hs_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [LEN_W-1:0]  push_len,
    output logic              discard,
    output logic [LEN_W-1:0]  discard_len
);

    localparam logic [LEN_W-1:0]  FRAME_CAP = LEN_W'(MAX_FRAME);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BUF_BYTES - 1);

    fa_state_e         state_q, state_d;
    logic [PC_W-1:0]   mps_q;       // packet size limit latched at start
    logic [PC_W-1:0]   pkt_cnt;     // bytes seen in packet, saturating
    logic [LEN_W-1:0]  frame_cnt;   // bytes written in current frame
    logic              ovf_q;       // frame went past the cap
    logic              acc_q;       // current packet was accepted
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] frame_base;

    logic [CNT_W-1:0]  need;
    logic              room;
    logic              take;
    logic              frame_end;

    assign need = hs_mode ? CNT_W'(HS_MPS) : CNT_W'(FS_MPS);
    assign room = (free_cnt >= need) && !q_full;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pkt_start) state_d = room ? ST_RECV : ST_DROP;
            ST_RECV: if (pkt_end)   state_d = ST_DONE;
            ST_DROP: if (pkt_end)   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        take        = (state_q == ST_RECV) && in_valid && (pkt_cnt < mps_q);
        mem_we      = take && !ovf_q && (frame_cnt < FRAME_CAP);
        mem_addr    = wr_ptr;
        mem_wdata   = in_data;
        hs_valid    = (state_q == ST_DONE);
        hs_ack      = acc_q;
        frame_end   = (state_q == ST_DONE) && acc_q && (pkt_cnt < mps_q);
        push        = frame_end && !ovf_q && (frame_cnt != '0);
        push_addr   = frame_base;
        push_len    = frame_cnt;
        discard     = frame_end && ovf_q;
        discard_len = frame_cnt;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mps_q      <= PC_W'(FS_MPS);
            pkt_cnt    <= '0;
            frame_cnt  <= '0;
            ovf_q      <= 1'b0;
            acc_q      <= 1'b0;
            wr_ptr     <= '0;
            frame_base <= '0;
        end else begin
            if (state_q == ST_IDLE && pkt_start) begin
                mps_q   <= hs_mode ? PC_W'(HS_MPS) : PC_W'(FS_MPS);
                pkt_cnt <= '0;
                acc_q   <= room;
            end
            if (take) begin
                pkt_cnt <= pkt_cnt + 1'b1;
                if (mem_we) begin
                    frame_cnt <= frame_cnt + 1'b1;
                    wr_ptr    <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + 1'b1;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
            if (frame_end) begin
                frame_cnt <= '0;
                ovf_q     <= 1'b0;
                if (ovf_q) wr_ptr     <= frame_base;
                else       frame_base <= wr_ptr;
            end
        end
    end

endmodule

// File: rtl/usb_frame_asm.sv
// Top: USB bulk-out packets to Ethernet frames in a circular buffer.
module usb_frame_asm #(
    parameter int BUF_BYTES = 4608,
    parameter int MAX_FRAME = 1518,
    parameter int FS_MPS    = 64,
    parameter int HS_MPS    = 512,
    parameter int Q_DEPTH   = 8,
    parameter int ADDR_W    = $clog2(BUF_BYTES),
    parameter int LEN_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_mode,
    input  logic              pkt_start,
    input  logic              pkt_end,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              hs_valid,
    output logic              hs_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              txq_valid,
    output logic [ADDR_W-1:0] txq_addr,
    output logic [LEN_W-1:0]  txq_len,
    input  logic              txq_pop,
    input  logic              tx_done,
    input  logic [LEN_W-1:0]  tx_done_len
);

    localparam int CNT_W  = $clog2(BUF_BYTES + 1);
    localparam int PC_W   = $clog2(HS_MPS + 1);
    localparam int DESC_W = ADDR_W + LEN_W;

    logic [CNT_W-1:0]  free_cnt;
    logic              q_full;
    logic              push;
    logic [ADDR_W-1:0] push_addr;
    logic [LEN_W-1:0]  push_len;
    logic              discard;
    logic [LEN_W-1:0]  discard_len;
    logic [DESC_W-1:0] q_out;

    fa_ctrl #(
        .BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME),
        .FS_MPS(FS_MPS), .HS_MPS(HS_MPS),
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .PC_W(PC_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode),
        .pkt_start(pkt_start), .pkt_end(pkt_end),
        .in_valid(in_valid), .in_data(in_data),
        .free_cnt(free_cnt), .q_full(q_full),
        .hs_valid(hs_valid), .hs_ack(hs_ack),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .push(push), .push_addr(push_addr), .push_len(push_len),
        .discard(discard), .discard_len(discard_len)
    );

    fa_space #(
        .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) space_i (
        .clk(clk), .rst_n(rst_n), .dec(mem_we),
        .give_a(discard), .give_a_len(discard_len),
        .give_b(tx_done), .give_b_len(tx_done_len),
        .free_cnt(free_cnt)
    );

    fa_desc_fifo #(
        .W(DESC_W), .DEPTH(Q_DEPTH)
    ) queue_i (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din({push_addr, push_len}),
        .pop(txq_pop), .dout(q_out),
        .valid(txq_valid), .full(q_full)
    );

    assign txq_addr = q_out[DESC_W-1:LEN_W];
    assign txq_len  = q_out[LEN_W-1:0];

endmodule

// File: rtl/usb_frame_asm_chk.sv
// Property checker bound into the frame assembler.
module usb_frame_asm_chk #(
    parameter int BUF_BYTES = 4608,
    parameter int MAX_FRAME = 1518,
    parameter int ADDR_W    = 13,
    parameter int LEN_W     = 11,
    parameter int CNT_W     = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              txq_valid,
    input logic [LEN_W-1:0]  txq_len,
    input logic              tx_done,
    input logic [CNT_W-1:0]  free_cnt
);

    // R2: handshake is a single-cycle pulse
    p_hs_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    // R4: writes never leave the buffer range
    p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < BUF_BYTES));

    // R4: back-to-back writes use the next address, wrapping at the end
    p_addr_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        (mem_addr == ((int'($past(mem_addr)) == BUF_BYTES - 1) ?
                      ADDR_W'(0) : $past(mem_addr) + 1'b1)));

    // R6, R7: a queued frame is never empty nor beyond the cap
    p_desc_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txq_valid |-> (txq_len != '0 && int'(txq_len) <= MAX_FRAME));

    // R8: free space never exceeds the buffer
    p_free_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) <= BUF_BYTES);

    // R8: each written byte takes one byte of space
    p_write_debit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !tx_done) |=> (free_cnt == $past(free_cnt) - 1'b1));

endmodule

bind usb_frame_asm usb_frame_asm_chk #(
    .BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .hs_valid(hs_valid),
    .mem_we(mem_we), .mem_addr(mem_addr),
    .txq_valid(txq_valid), .txq_len(txq_len),
    .tx_done(tx_done), .free_cnt(free_cnt)
);

// File: tb/usb_frame_asm_tb_top.sv
`timescale 1ns/100ps
module usb_frame_asm_tb_top;

    localparam int BUF  = 4608;
    localparam int MAXF = 1518;
    localparam int QD   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_mode = 1'b0, pkt_start = 1'b0, pkt_end = 1'b0, in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        hs_valid, hs_ack, mem_we, txq_valid;
    logic [12:0] mem_addr, txq_addr;
    logic [7:0]  mem_wdata;
    logic [10:0] txq_len;
    logic        txq_pop = 1'b0, tx_done = 1'b0;
    logic [10:0] tx_done_len = '0;

    always #2.5 clk = ~clk;

    usb_frame_asm dut_i (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode),
        .pkt_start(pkt_start), .pkt_end(pkt_end),
        .in_valid(in_valid), .in_data(in_data),
        .hs_valid(hs_valid), .hs_ack(hs_ack),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .txq_valid(txq_valid), .txq_addr(txq_addr), .txq_len(txq_len),
        .txq_pop(txq_pop), .tx_done(tx_done), .tx_done_len(tx_done_len)
    );

    // Buffer model filled from the write port
    logic [7:0] mem_model [BUF];
    logic [7:0] exp_mem   [BUF];
    int wr_cnt = 0;
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            mem_model[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    // Reference state derived from the requirements
    int exp_free = BUF;
    int m_wp = 0, m_base = 0, m_fcnt = 0;
    bit m_ovf = 1'b0;
    int eq_addr[$];
    int eq_len[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Send one packet and check handshake, write count and queue head
    task automatic send_pkt(input int len, input bit hs, input string tag);
        int  mps;
        bit  ack;
        int  wr0;
        int  expw;
        mps  = hs ? 512 : 64;
        ack  = (exp_free >= mps) && (eq_len.size() < QD);
        wr0  = wr_cnt;
        expw = 0;
        @(negedge clk); hs_mode = hs; pkt_start = 1'b1;
        @(negedge clk); pkt_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            in_valid = 1'b1; in_data = b;
            if (ack && i < mps) begin
                if (!m_ovf && m_fcnt < MAXF) begin
                    exp_mem[m_wp] = b;
                    m_wp = (m_wp + 1) % BUF;
                    m_fcnt++; exp_free--; expw++;
                end else m_ovf = 1'b1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0; pkt_end = 1'b1;
        @(negedge clk); pkt_end = 1'b0;
        chk(hs_valid === 1'b1, "R2", {tag, " hs_valid"}, int'(hs_valid), 1);
        chk(hs_ack === ack, "R2", {tag, " hs_ack"}, int'(hs_ack), int'(ack));
        if (ack && len < mps) begin
            if (m_ovf) begin
                exp_free += m_fcnt;
                m_wp = m_base;
            end else begin
                if (m_fcnt > 0) begin
                    eq_addr.push_back(m_base);
                    eq_len.push_back(m_fcnt);
                end
                m_base = m_wp;
            end
            m_fcnt = 0; m_ovf = 1'b0;
        end
        @(negedge clk);
        chk(hs_valid === 1'b0, "R2", {tag, " hs_valid drop"}, int'(hs_valid), 0);
        chk((wr_cnt - wr0) == expw, ack ? "R4" : "R3", {tag, " bytes written"},
            wr_cnt - wr0, expw);
        chk(txq_valid === (eq_len.size() > 0), "R6", {tag, " txq_valid"},
            int'(txq_valid), int'(eq_len.size() > 0));
        if (eq_len.size() > 0) begin
            chk(int'(txq_addr) == eq_addr[0], "R6", {tag, " txq_addr"},
                int'(txq_addr), eq_addr[0]);
            chk(int'(txq_len) == eq_len[0], "R6", {tag, " txq_len"},
                int'(txq_len), eq_len[0]);
        end
    endtask

    // MAC: take the head descriptor, check its bytes, release its space
    task automatic pop_one();
        int a, l, bad;
        a = eq_addr[0]; l = eq_len[0]; bad = 0;
        chk(txq_valid === 1'b1, "R9", "head present", int'(txq_valid), 1);
        chk(int'(txq_addr) == a && int'(txq_len) == l, "R9", "head order",
            int'(txq_len), l);
        for (int i = 0; i < l; i++)
            if (mem_model[(a + i) % BUF] !== exp_mem[(a + i) % BUF]) bad++;
        chk(bad == 0, "R4", "frame bytes in buffer", bad, 0);
        txq_pop = 1'b1;
        @(negedge clk); txq_pop = 1'b0;
        tx_done = 1'b1; tx_done_len = 11'(l);
        @(negedge clk); tx_done = 1'b0;
        void'(eq_addr.pop_front());
        void'(eq_len.pop_front());
        exp_free += l;
    endtask

    task automatic pop_all();
        while (eq_len.size() > 0) pop_one();
        chk(txq_valid === 1'b0, "R9", "queue drained", int'(txq_valid), 0);
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(hs_valid === 1'b0, "R10", "hs_valid", int'(hs_valid), 0);
        chk(mem_we === 1'b0, "R10", "mem_we", int'(mem_we), 0);
        chk(txq_valid === 1'b0, "R10", "txq_valid", int'(txq_valid), 0);

        // R5: full-speed frame closed by a short packet (138 bytes at 0)
        send_pkt(64, 1'b0, "R5 fs a");
        send_pkt(64, 1'b0, "R5 fs b");
        send_pkt(10, 1'b0, "R5 fs short");
        chk(int'(txq_len) == 138 && txq_addr == 0, "R10", "first frame at 0",
            int'(txq_addr), 0);
        // R5: closed by a zero-length packet
        send_pkt(64, 1'b0, "R5 zl a");
        send_pkt(64, 1'b0, "R5 zl b");
        send_pkt(0, 1'b0, "R5 zlp");
        // R1: high speed, 100 bytes ends the frame
        send_pkt(512, 1'b1, "R1 hs a");
        send_pkt(512, 1'b1, "R1 hs b");
        send_pkt(100, 1'b1, "R1 hs short");
        pop_all();

        // R6: lone zero-length packet gives no descriptor
        send_pkt(0, 1'b0, "R6 empty");

        // R7: 1536-byte frame is dropped, next frame reuses its start
        send_pkt(512, 1'b1, "R7 big a");
        send_pkt(512, 1'b1, "R7 big b");
        send_pkt(512, 1'b1, "R7 big c");
        send_pkt(0, 1'b1, "R7 big end");
        send_pkt(20, 1'b0, "R7 after drop");
        pop_all();

        // R1, R4: 70 bytes at full speed store only 64 and continue
        send_pkt(70, 1'b0, "R1 fs long");
        send_pkt(5, 1'b0, "R1 fs tail");
        pop_all();

        // R2, R3, R8: fill the buffer until space runs short
        for (int k = 0; k < 4; k++) begin
            send_pkt(512, 1'b1, "R8 fill a");
            send_pkt(488, 1'b1, "R8 fill b");
        end
        send_pkt(512, 1'b1, "R8 last room");
        send_pkt(512, 1'b1, "R3 nak space");
        pop_one();
        send_pkt(512, 1'b1, "R8 after release");
        send_pkt(100, 1'b1, "R8 close");
        pop_all();

        // R2, R9: eight queued frames, ninth start is refused
        for (int k = 0; k < QD; k++) send_pkt(10, 1'b0, "R9 fill queue");
        send_pkt(10, 1'b0, "R2 nak queue full");
        pop_all();

        // Random mix of lengths, speeds and releases
        for (int k = 0; k < 250; k++) begin
            bit hs;
            int mps, r, len;
            hs  = ($urandom % 4) == 0;
            mps = hs ? 512 : 64;
            r   = $urandom % 8;
            if (r == 0)      len = 0;
            else if (r < 4)  len = 1 + ($urandom % (mps - 1));
            else if (r < 7)  len = mps;
            else             len = mps + 2;
            send_pkt(len, hs, "R4 random");
            if (eq_len.size() > 0 && ($urandom % 3) == 0) pop_one();
        end
        send_pkt(0, 1'b0, "R5 random close");
        pop_all();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule